// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block sits on the master side of a two-wire serial bus. It decides when a serial EEPROM has finished its internal program cycle. While a write cycle is in progress the memory ignores the bus and returns no acknowledge. The poller therefore probes it again and again. Each probe is a start condition followed by the device-select byte with the read/write bit cleared. When the memory acknowledges that select byte, the poller moves straight on to the caller's next operation and does not send the select again.

The block drives a byte engine through a small command interface. Its commands are start, write byte, stop and repeated start, each completed by a done strobe that carries the acknowledge result. A caller loads the device address, the byte address and the kind of follow-up operation, then pulses a go input. On a write follow-up the poller sends the byte address and hands the bus back to the caller, who sends the data bytes. On a read follow-up it sends the byte address and then a repeated start, so the caller can continue with the read-mode select. If there is no follow-up, it closes the bus with a stop. A done pulse reports how many probes the whole run took. If the probe limit is reached, a timeout pulse is raised instead.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `cmd_valid_o`=0, `done_o`=0, `timeout_o`=0, `poll_cnt_o`=0.
- R2: Each probe issues command START (`cmd_o`=0), then WRITE (`cmd_o`=1) with `cmd_data_o` = {`dev_addr_i`,1'b0}.
- R3: A probe whose select byte is not acknowledged (`cmd_ack_i`=0 with `cmd_done_i`) is followed by STOP (`cmd_o`=2), then a new probe.
- R4: When `next_op_i`=1 (write) and the select is acknowledged, the only further command is WRITE of `byte_addr_i`. No stop and no repeated start follow.
- R5: When `next_op_i`=2 (read) and the select is acknowledged, the block issues WRITE of `byte_addr_i` and then RESTART (`cmd_o`=3).
- R6: When `next_op_i` is 0 or 3 (no memory access) and the select is acknowledged, the block issues a single STOP.
- R7: At the end of a successful run `done_o` pulses for exactly one cycle, one cycle after the last command completes. `poll_cnt_o` then holds the number of probes made, including the acknowledged one, until the next go.
- R8: After MAX_POLLS probes without acknowledge the block issues STOP and pulses `timeout_o` for one cycle. `poll_cnt_o`=MAX_POLLS, `done_o` stays low and the block returns to idle.
- R9: `go_i` is ignored while `busy_o`=1. The command sequence and the latched operands are not affected.
- R10: `cmd_valid_o`, `cmd_o` and `cmd_data_o` are held stable from the time a command is raised until `cmd_done_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start a polling run (taken only when idle) |
| dev_addr_i | input | 7 | Device address for the select byte |
| byte_addr_i | input | 8 | Memory byte address for the follow-up |
| next_op_i | input | 2 | Follow-up: 0 none, 1 write, 2 read, 3 none |
| cmd_valid_o | output | 1 | Command request to the byte engine |
| cmd_o | output | 2 | 0 START, 1 WRITE, 2 STOP, 3 RESTART |
| cmd_data_o | output | 8 | Byte to send with WRITE |
| cmd_done_i | input | 1 | Engine finished the current command |
| cmd_ack_i | input | 1 | Acknowledge received for a WRITE (valid with done) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: run finished successfully |
| timeout_o | output | 1 | One-cycle pulse: probe limit reached |
| poll_cnt_o | output | 5 | Probes made in the current or last run |

## Verification
A wrong state in this sequencer shows up at once in the command stream. A missing or extra stop, a select byte with the read bit set, or a byte address sent before the acknowledge all appear within one command of the fault. The bench therefore records every completed command and compares the whole list against the list built from the requirements. A miscounted probe shows up in `poll_cnt_o` at the done or timeout pulse, and a lost branch shows up as a missing pulse within a few commands.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;
  typedef enum logic [1:0] {
    CMD_START   = 2'd0,
    CMD_WRITE   = 2'd1,
    CMD_STOP    = 2'd2,
    CMD_RESTART = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE2 = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_SEL,
    S_RETRY_STOP,
    S_ADDR,
    S_RESTART,
    S_END_STOP,
    S_TO_STOP
  } state_e;
endpackage

// File: rtl/ack_poll_ctr.sv
module ack_poll_ctr #(
  parameter int MAX_POLLS = 16,
  localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LastVal = CNT_W'(MAX_POLLS - 1);
  localparam logic [CNT_W-1:0] MaxVal  = CNT_W'(MAX_POLLS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // next increment reaches the limit
  assign last_o = (cnt_q == LastVal);
  assign cnt_o  = cnt_q;

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MaxVal);
endmodule

// File: rtl/ack_poll_cmd_mux.sv
module ack_poll_cmd_mux
  import ack_poll_pkg::*;
#(
  parameter int DEV_W  = 7,
  parameter int ADDR_W = 8
) (
  input  state_e            state_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output cmd_e              cmd_o,
  output logic [7:0]        data_o
);
  always_comb begin
    valid_o = 1'b1;
    cmd_o   = CMD_STOP;
    data_o  = '0;
    unique case (state_i)
      S_START:   cmd_o = CMD_START;
      S_SEL: begin
        cmd_o  = CMD_WRITE;
        data_o = 8'({dev_i, 1'b0}); // write-mode select as busy probe
      end
      S_ADDR: begin
        cmd_o  = CMD_WRITE;
        data_o = 8'(addr_i);
      end
      S_RESTART: cmd_o = CMD_RESTART;
      S_RETRY_STOP, S_END_STOP, S_TO_STOP: cmd_o = CMD_STOP;
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
  import ack_poll_pkg::*;
#(
  parameter int MAX_POLLS = 16,
  parameter int DEV_W     = 7,
  parameter int ADDR_W    = 8,
  localparam int CNT_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [1:0]        next_op_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [7:0]        cmd_data_o,
  input  logic              cmd_done_i,
  input  logic              cmd_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  poll_cnt_o
);
  state_e            state_q, state_d;
  logic [DEV_W-1:0]  dev_q;
  logic [ADDR_W-1:0] addr_q;
  op_e               op_q;
  logic              done_q, to_q;
  logic              start_run, ctr_inc, ctr_last;
  logic              finish_ok, finish_to;
  cmd_e              cmd_w;

  assign start_run = go_i && (state_q == S_IDLE);
  assign ctr_inc   = (state_q == S_SEL) && cmd_done_i;

  ack_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_ctr (
    .clk_i, .rst_ni,
    .clr_i (start_run),
    .inc_i (ctr_inc),
    .cnt_o (poll_cnt_o),
    .last_o(ctr_last)
  );

  ack_poll_cmd_mux #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_mux (
    .state_i(state_q),
    .dev_i  (dev_q),
    .addr_i (addr_q),
    .valid_o(cmd_valid_o),
    .cmd_o  (cmd_w),
    .data_o (cmd_data_o)
  );
  assign cmd_o = cmd_w;

  always_comb begin
    state_d   = state_q;
    finish_ok = 1'b0;
    finish_to = 1'b0;
    unique case (state_q)
      S_IDLE:       if (go_i) state_d = S_START;
      S_START:      if (cmd_done_i) state_d = S_SEL;
      S_SEL: if (cmd_done_i) begin
        if (cmd_ack_i) begin
          if (op_q == OP_WRITE || op_q == OP_READ) state_d = S_ADDR;
          else                                     state_d = S_END_STOP;
        end else begin
          state_d = ctr_last ? S_TO_STOP : S_RETRY_STOP;
        end
      end
      S_RETRY_STOP: if (cmd_done_i) state_d = S_START;
      S_ADDR: if (cmd_done_i) begin
        if (op_q == OP_READ) state_d = S_RESTART;
        else begin
          state_d   = S_IDLE;
          finish_ok = 1'b1;
        end
      end
      S_RESTART, S_END_STOP: if (cmd_done_i) begin
        state_d   = S_IDLE;
        finish_ok = 1'b1;
      end
      S_TO_STOP: if (cmd_done_i) begin
        state_d   = S_IDLE;
        finish_to = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dev_q   <= '0;
      addr_q  <= '0;
      op_q    <= OP_NONE;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_ok;
      to_q    <= finish_to;
      if (start_run) begin
        dev_q  <= dev_addr_i;
        addr_q <= byte_addr_i;
        op_q   <= op_e'(next_op_i);
      end
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;

  a_r10_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_data_o));
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  a_r8_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !busy_o && poll_cnt_o == CNT_W'(MAX_POLLS));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);
  a_r9_operands_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(dev_q) && $stable(addr_q) && $stable(op_q));
endmodule

// File: tb/tb_ack_poll_seq.sv
`timescale 1ns/1ps
module tb_ack_poll_seq;
  localparam int MAXP = 6;
  localparam int CW   = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 1'b0;
  logic [6:0] dev = '0;
  logic [7:0] baddr = '0;
  logic [1:0] op = '0;
  logic cmd_valid, cmd_done = 1'b0, cmd_ack = 1'b0;
  logic [1:0] cmd;
  logic [7:0] cmd_data;
  logic busy, done, tmo;
  logic [CW-1:0] pcnt;

  int errors = 0, checks = 0;
  int nacks_left = 0;
  logic [7:0] sel_byte = '0;
  int lat = 0;
  int n_log = 0;
  logic [1:0] log_cmd [64];
  logic [7:0] log_dat [64];
  int hold_viol = 0;
  logic [1:0] prev_cmd;
  logic [7:0] prev_dat;
  logic waiting = 1'b0;

  always #2.5 clk = ~clk;

  ack_poll_seq #(.MAX_POLLS(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .dev_addr_i(dev), .byte_addr_i(baddr),
    .next_op_i(op), .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_data_o(cmd_data),
    .cmd_done_i(cmd_done), .cmd_ack_i(cmd_ack), .busy_o(busy), .done_o(done),
    .timeout_o(tmo), .poll_cnt_o(pcnt)
  );

  // byte engine model: completes each command after 3 cycles
  always @(posedge clk) begin
    if (cmd_done) begin
      cmd_done <= 1'b0;
      cmd_ack  <= 1'b0;
      lat      <= 0;
      waiting  <= 1'b0;
    end else if (cmd_valid) begin
      if (waiting && (cmd != prev_cmd || cmd_data != prev_dat)) hold_viol <= hold_viol + 1;
      waiting  <= 1'b1;
      prev_cmd <= cmd;
      prev_dat <= cmd_data;
      if (lat == 2) begin
        cmd_done <= 1'b1;
        if (n_log < 64) begin
          log_cmd[n_log] <= cmd;
          log_dat[n_log] <= cmd_data;
        end
        n_log <= n_log + 1;
        if (cmd == 2'd1 && cmd_data == sel_byte && nacks_left > 0) begin
          cmd_ack    <= 1'b0;
          nacks_left <= nacks_left - 1;
        end else cmd_ack <= 1'b1;
      end else lat <= lat + 1;
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one poll and checks command list, done/timeout and count
  task automatic run_case(input string req, input logic [6:0] d, input logic [7:0] a,
                          input logic [1:0] o, input int nk, input bit poke_go);
    logic [1:0] ec [64];
    logic [7:0] ed [64];
    int ne = 0, probes = 0, seen_done = 0, seen_to = 0, cnt_at_end = 0, mism = 0;
    bit timed_out = (nk >= MAXP);
    for (int i = 0; i < MAXP; i++) begin
      ec[ne] = 2'd0; ed[ne] = 8'h00; ne++;
      ec[ne] = 2'd1; ed[ne] = {d, 1'b0}; ne++;
      probes++;
      if (i < nk) begin ec[ne] = 2'd2; ed[ne] = 8'h00; ne++; end
      if (i >= nk || i == MAXP - 1) break;
    end
    if (!timed_out) begin
      if (o == 2'd1 || o == 2'd2) begin ec[ne] = 2'd1; ed[ne] = a; ne++; end
      if (o == 2'd2) begin ec[ne] = 2'd3; ed[ne] = 8'h00; ne++; end
      if (o == 2'd0 || o == 2'd3) begin ec[ne] = 2'd2; ed[ne] = 8'h00; ne++; end
    end
    @(negedge clk);
    n_log = 0;
    nacks_left = nk;
    sel_byte = {d, 1'b0};
    dev = d; baddr = a; op = o; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      if (poke_go && c == 10) begin
        dev = ~d; baddr = ~a; op = 2'd0; go = 1'b1;  // R9 go while busy
      end else go = 1'b0;
      if (done) begin seen_done = 1; cnt_at_end = pcnt; end
      if (tmo)  begin seen_to = 1; cnt_at_end = pcnt; end
      if (seen_done || seen_to) break;
      @(negedge clk);
    end
    go = 1'b0;
    @(negedge clk);
    chk({req, " pulse single cycle (R7)"}, int'(done) + int'(tmo), 0);
    chk({req, " busy cleared"}, int'(busy), 0);
    chk({req, " command count"}, n_log, ne);
    for (int i = 0; i < ne && i < n_log; i++)
      if (log_cmd[i] != ec[i] || (ec[i] == 2'd1 && log_dat[i] != ed[i])) mism++;
    chk({req, " command sequence"}, mism, 0);
    if (timed_out) begin
      chk({req, " timeout seen (R8)"}, seen_to, 1);
      chk({req, " no done on timeout (R8)"}, seen_done, 0);
      chk({req, " count at timeout (R8)"}, cnt_at_end, MAXP);
    end else begin
      chk({req, " done seen (R7)"}, seen_done, 1);
      chk({req, " probe count (R7)"}, cnt_at_end, probes);
      chk({req, " count held (R7)"}, int'(pcnt), probes);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 timeout", int'(tmo), 0);
    chk("R1 poll count", int'(pcnt), 0);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R2 R4 write ready", 7'h50, 8'h3c, 2'd1, 0, 1'b0);
    run_case("R3 R4 write busy", 7'h51, 8'h07, 2'd1, 3, 1'b0);
    run_case("R5 read after busy", 7'h2a, 8'hf8, 2'd2, 2, 1'b0);
    run_case("R6 no access", 7'h7f, 8'h11, 2'd0, 1, 1'b0);
    run_case("R6 no access op3", 7'h01, 8'h22, 2'd3, 0, 1'b0);
    run_case("R8 limit", 7'h33, 8'h44, 2'd1, MAXP, 1'b0);
    run_case("R3 last probe ok", 7'h34, 8'h45, 2'd2, MAXP - 1, 1'b0);
    run_case("R9 go while busy", 7'h55, 8'h66, 2'd2, 3, 1'b1);
    chk("R10 command hold", hold_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule